// File: doc/BRIEF.md
# Per-Line Configurable Interrupt Detector

This block turns a set of already-synchronized input lines into interrupt status. Every line has its own trigger mode: level-sensitive (active high or active low), single edge (rising or falling), or both edges. Edge events are latched until software writes a 1 to the line's bit in a clear register. A level condition is never latched. Its status follows the line directly and goes away when the line does.

Software sets the mode and enable bits through a simple register write port and reads configuration and status back through a combinational read port. Raw status, masked status (raw ANDed with the per-line enables) and one combined interrupt output are also brought out as ports for the interrupt fabric around the block.

Top module: `irq_line_detector`

## Requirements
- R1: The registers are decoded on the full 12-bit address: mode-select 0x404, dual-edge 0x408, polarity 0x40C, enable 0x410, raw status 0x414, masked status 0x418, clear 0x41C. The first four read back the last value written to them. A write takes effect from the next clock. Reads of 0x41C and of any unmapped address return 0.
- R2: A line whose mode-select bit is 1 is level-sensitive. Its raw status equals the line when its polarity bit is 1 and the inverted line when its polarity bit is 0. It changes in the same cycle as the line, and no clear is needed.
- R3: A line with mode-select 0 and dual-edge 0 is single-edge. Polarity 1 selects rising and polarity 0 selects falling. Each clock compares the line with its value at the previous clock. A detected edge sets the raw bit, which is visible after that clock.
- R4: A line with mode-select 0 and dual-edge 1 latches on both rising and falling edges, whatever its polarity bit holds.
- R5: A latched edge bit stays set until a write to 0x41C with a 1 in that bit position. Bits written as 0 leave their lines unchanged.
- R6: When a qualifying edge and a clear of the same line fall on the same clock, the raw bit ends up set.
- R7: Masked status equals raw status ANDed with the enable register, and irq is 1 exactly when some masked bit is 1.
- R8: Changing an enable bit never changes raw status.
- R9: After reset, all configuration registers, latched edges and the stored previous line values are 0, so raw status, masked status and irq are 0.
- R10: While a line is level-sensitive, its edge latch is held clear. A line switched back to edge mode starts with no pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | N_LINES | Register write data, one bit per line |
| rd_addr | input | 12 | Register read address |
| rd_data | output | N_LINES | Combinational read data |
| line_i | input | N_LINES | Synchronized input lines |
| raw_status | output | N_LINES | Per-line raw interrupt status |
| masked_status | output | N_LINES | Raw status ANDed with enables |
| irq | output | 1 | OR of all masked status bits |

## Verification
The bench builds the block at its default width of eight lines. That width lets a single configuration hold a mix of level-high, level-low, rising, falling and dual-edge lines, so lines in different modes see the same stimulus in the same cycle. At that width the bench also checks a clear and a new edge landing together on one line while a neighbouring line is only cleared. After the directed phases, a pseudo-random phase changes the line pattern every cycle and rewrites configuration registers often, which exercises mode changes while edges are pending.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;

    localparam int ADDR_W = 12;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t OFS_MODE = 12'h404;
    localparam addr_t OFS_DUAL = 12'h408;
    localparam addr_t OFS_POL  = 12'h40C;
    localparam addr_t OFS_EN   = 12'h410;
    localparam addr_t OFS_RAW  = 12'h414;
    localparam addr_t OFS_MASK = 12'h418;
    localparam addr_t OFS_CLR  = 12'h41C;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_MODE, SEL_DUAL, SEL_POL, SEL_EN, SEL_RAW, SEL_MASK, SEL_CLR
    } reg_sel_e;

    typedef struct packed {
        logic level;    // 1: level-sensitive, 0: edge
        logic dual;     // edge on both directions
        logic pol;      // high/rising when 1, low/falling when 0
    } line_mode_t;

    function automatic reg_sel_e decode(addr_t a);
        case (a)
            OFS_MODE: return SEL_MODE;
            OFS_DUAL: return SEL_DUAL;
            OFS_POL:  return SEL_POL;
            OFS_EN:   return SEL_EN;
            OFS_RAW:  return SEL_RAW;
            OFS_MASK: return SEL_MASK;
            OFS_CLR:  return SEL_CLR;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic edge_hit(line_mode_t m, logic cur, logic prev);
        if (m.dual)
            return cur ^ prev;
        else if (m.pol)
            return cur & ~prev;
        else
            return ~cur & prev;
    endfunction

    function automatic logic level_active(line_mode_t m, logic cur);
        return m.pol ? cur : ~cur;
    endfunction

endpackage

// File: rtl/irqdet_regs.sv
module irqdet_regs
    import irqdet_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  addr_t                    wr_addr,
    input  logic [N_LINES-1:0]       wr_data,
    input  addr_t                    rd_addr,
    input  logic [N_LINES-1:0]       raw_i,
    input  logic [N_LINES-1:0]       masked_i,
    output line_mode_t [N_LINES-1:0] mode_o,
    output logic [N_LINES-1:0]       en_o,
    output logic [N_LINES-1:0]       clr_o,
    output logic [N_LINES-1:0]       rd_data
);

    logic [N_LINES-1:0] mode_q, dual_q, pol_q, en_q;
    reg_sel_e wsel, rsel;

    assign wsel = wr_en ? decode(wr_addr) : SEL_NONE;
    assign rsel = decode(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            dual_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else begin
            case (wsel)
                SEL_MODE: mode_q <= wr_data;
                SEL_DUAL: dual_q <= wr_data;
                SEL_POL:  pol_q  <= wr_data;
                SEL_EN:   en_q   <= wr_data;
                default: ;
            endcase
        end
    end

    assign clr_o = (wsel == SEL_CLR) ? wr_data : '0;
    assign en_o  = en_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_mode
        assign mode_o[i] = '{level: mode_q[i], dual: dual_q[i], pol: pol_q[i]};
    end

    always_comb begin
        case (rsel)
            SEL_MODE: rd_data = mode_q;
            SEL_DUAL: rd_data = dual_q;
            SEL_POL:  rd_data = pol_q;
            SEL_EN:   rd_data = en_q;
            SEL_RAW:  rd_data = raw_i;
            SEL_MASK: rd_data = masked_i;
            default:  rd_data = '0;
        endcase
    end

    // R1: a write to the mode-select offset is held from the next clock
    assert_mode_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_MODE) |=> (mode_q == $past(wr_data)));

    // R1: no write to the enable offset leaves enables unchanged
    assert_en_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == OFS_EN) |=> $stable(en_q));

endmodule

// File: rtl/irqdet_line.sv
module irqdet_line
    import irqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_mode_t mode,
    input  logic       line_i,
    input  logic       clr_i,
    output logic       raw_o
);

    logic prev_q, latch_q, hit;

    assign hit = edge_hit(mode, line_i, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (mode.level)
                latch_q <= 1'b0;
            else if (hit)
                latch_q <= 1'b1;
            else if (clr_i)
                latch_q <= 1'b0;
        end
    end

    assign raw_o = mode.level ? level_active(mode, line_i) : latch_q;

    // R3/R6: a qualifying edge in edge mode latches even with a clear present
    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode.level && hit) |=> latch_q);

    // R5: a pending edge survives a cycle without clear
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !mode.level && !clr_i) |=> latch_q);

    // R5: a clear with no new edge removes the event
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode.level && !hit && clr_i) |=> !latch_q);

    // R10: level mode leaves no latched event behind
    assert_level_drops_latch_R10: assert property (@(posedge clk) disable iff (rst)
        mode.level |=> !latch_q);

endmodule

// File: rtl/irqdet_combine.sv
module irqdet_combine #(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] raw_i,
    input  logic [N_LINES-1:0] en_i,
    output logic [N_LINES-1:0] masked_o,
    output logic               irq_o
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_mask
        assign masked_o[i] = raw_i[i] & en_i[i];
    end

    assign irq_o = |masked_o;

endmodule

// File: rtl/irq_line_detector.sv
module irq_line_detector
    import irqdet_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [11:0]        wr_addr,
    input  logic [N_LINES-1:0] wr_data,
    input  logic [11:0]        rd_addr,
    output logic [N_LINES-1:0] rd_data,
    input  logic [N_LINES-1:0] line_i,
    output logic [N_LINES-1:0] raw_status,
    output logic [N_LINES-1:0] masked_status,
    output logic               irq
);

    line_mode_t [N_LINES-1:0] mode;
    logic [N_LINES-1:0] en, clr;

    irqdet_regs #(.N_LINES(N_LINES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .raw_i    (raw_status),
        .masked_i (masked_status),
        .mode_o   (mode),
        .en_o     (en),
        .clr_o    (clr),
        .rd_data  (rd_data)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irqdet_line u_line (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode[i]),
            .line_i (line_i[i]),
            .clr_i  (clr[i]),
            .raw_o  (raw_status[i])
        );

        // R2: an active-high level line tracks the pin in the same cycle
        assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
            (mode[i].level && mode[i].pol) |-> (raw_status[i] == line_i[i]));
    end

    irqdet_combine #(.N_LINES(N_LINES)) u_comb (
        .raw_i    (raw_status),
        .en_i     (en),
        .masked_o (masked_status),
        .irq_o    (irq)
    );

    // R7: the combined output only rises with an enabled raw bit behind it
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw_status & en) != '0));

    // R9: the first cycle after reset shows no status at all
    assert_reset_clean_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_status == '0 && !irq));

endmodule

// File: tb/sim_irq_line_detector.sv
module sim_irq_line_detector;

    localparam int N = 8;
    localparam logic [11:0] A_MODE = 12'h404, A_DUAL = 12'h408, A_POL = 12'h40C,
                            A_EN = 12'h410, A_RAW = 12'h414, A_MASK = 12'h418,
                            A_CLR = 12'h41C, A_NONE = 12'h400;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [11:0]  wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [11:0]  rd_addr = A_MODE;
    logic [N-1:0] rd_data;
    logic [N-1:0] line_i = '0;
    logic [N-1:0] raw_status, masked_status;
    logic         irq;

    irq_line_detector #(.N_LINES(N)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .line_i(line_i),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R9";
    bit    done = 0;

    // behavioural reference state
    logic [N-1:0] m_mode = '0, m_dual = '0, m_pol = '0, m_en = '0, m_lat = '0, m_prev = '0;

    always @(posedge clk) begin
        logic [N-1:0] clrv;
        clrv = (wr_en && wr_addr == A_CLR) ? wr_data : '0;
        if (rst) begin
            m_mode = '0; m_dual = '0; m_pol = '0; m_en = '0; m_lat = '0; m_prev = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit went_up, went_down, fire;
                went_up   = line_i[i] && !m_prev[i];
                went_down = !line_i[i] && m_prev[i];
                if (m_dual[i]) fire = went_up || went_down;
                else if (m_pol[i]) fire = went_up;
                else fire = went_down;
                if (m_mode[i]) m_lat[i] = 1'b0;
                else if (fire) m_lat[i] = 1'b1;
                else if (clrv[i]) m_lat[i] = 1'b0;
            end
            m_prev = line_i;
            if (wr_en) begin
                if (wr_addr == A_MODE) m_mode = wr_data;
                if (wr_addr == A_DUAL) m_dual = wr_data;
                if (wr_addr == A_POL)  m_pol  = wr_data;
                if (wr_addr == A_EN)   m_en   = wr_data;
            end
        end
    end

    function automatic logic [N-1:0] exp_raw();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = m_mode[i] ? (m_pol[i] ? line_i[i] : !line_i[i]) : m_lat[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_rd(logic [11:0] a);
        case (a)
            A_MODE:  return m_mode;
            A_DUAL:  return m_dual;
            A_POL:   return m_pol;
            A_EN:    return m_en;
            A_RAW:   return exp_raw();
            A_MASK:  return exp_raw() & m_en;
            default: return '0;
        endcase
    endfunction

    task automatic chk(string t, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, a quarter period after the falling edge
    always @(negedge clk) begin
        #5;
        if (!rst && !done) begin
            chk(tag, "raw", raw_status, exp_raw());
            chk(tag, "masked R7", masked_status, exp_raw() & m_en);
            chk(tag, "irq R7", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, ((exp_raw() & m_en) != '0)});
            chk(tag, "rd_data R1", rd_data, exp_rd(rd_addr));
        end
    end

    // read address sweeps every register and one unmapped address
    initial begin
        logic [11:0] seq [8];
        seq = '{A_MODE, A_DUAL, A_POL, A_EN, A_RAW, A_MASK, A_CLR, A_NONE};
        for (int k = 0; ; k++) begin
            @(negedge clk);
            rd_addr = seq[k % 8];
        end
    end

    task automatic wr(logic [11:0] a, logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive(logic [N-1:0] v);
        @(negedge clk);
        line_i = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] raw_before;
        logic [15:0]  lfsr;

        // R9: reset state
        tag = "R9";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R9", "raw after reset", raw_status, '0);
        chk("R9", "irq after reset", {{(N-1){1'b0}}, irq}, '0);
        idle(8);

        // R1: register write and readback
        tag = "R1";
        wr(A_DUAL, 8'hA5);
        wr(A_POL, 8'h3C);
        wr(A_EN, 8'h96);
        idle(10);
        wr(A_DUAL, 8'h00);
        wr(A_POL, 8'h00);
        wr(A_EN, 8'h00);
        idle(8);

        // R2: level mode, low nibble active high, high nibble active low
        tag = "R2";
        wr(A_EN, 8'hFF);
        wr(A_POL, 8'h0F);
        wr(A_MODE, 8'hFF);
        drive(8'h3C);
        #5;
        chk("R2", "level mix 3C", raw_status, 8'hCC);
        drive(8'hF0);
        #5;
        chk("R2", "level released", raw_status, 8'h00);
        drive(8'h5A); drive(8'hA5); drive(8'h00);
        idle(4);

        // R3: single edge, low nibble rising, high nibble falling
        tag = "R3";
        wr(A_MODE, 8'h00);
        wr(A_CLR, 8'hFF);
        drive(8'hFF);
        idle(2);
        drive(8'h00);
        idle(2);
        #5;
        chk("R3", "rise then fall latched", raw_status, 8'hFF);

        // R5: selective clear, zero bits ignored
        tag = "R5";
        wr(A_CLR, 8'h05);
        #5;
        chk("R5", "partial clear", raw_status, 8'hFA);
        wr(A_CLR, 8'h00);
        #5;
        chk("R5", "zero clear no effect", raw_status, 8'hFA);

        // R6: new rising edge on line 0 together with clearing lines 0 and 1
        tag = "R6";
        wr(A_CLR, 8'hFF);
        @(negedge clk);
        line_i = 8'h01; wr_en = 1'b1; wr_addr = A_CLR; wr_data = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        #5;
        chk("R6", "edge beats clear", raw_status, 8'h01);
        drive(8'h00);
        idle(3);

        // R4: both edges on the high nibble, polarity ignored there
        tag = "R4";
        wr(A_DUAL, 8'hF0);
        wr(A_POL, 8'h5F);
        wr(A_CLR, 8'hFF);
        drive(8'h30);
        idle(2);
        wr(A_CLR, 8'h30);
        drive(8'h00);
        idle(2);
        drive(8'hC0);
        idle(2);
        drive(8'h00);
        idle(3);

        // R7 and R8: enable only masks, raw untouched
        tag = "R8";
        wr(A_EN, 8'hFF);
        #5;
        raw_before = raw_status;
        wr(A_EN, 8'h00);
        #5;
        chk("R8", "raw unchanged by enable", raw_status, raw_before);
        chk("R7", "no enabled line, no irq", {{(N-1){1'b0}}, irq}, '0);
        tag = "R7";
        wr(A_EN, 8'h81);
        idle(4);

        // R10: latched events discarded by a visit to level mode
        tag = "R10";
        wr(A_DUAL, 8'hFF);
        drive(8'hFF);
        idle(2);
        wr(A_POL, 8'hFF);
        wr(A_MODE, 8'hFF);
        drive(8'h00);
        wr(A_MODE, 8'h00);
        idle(1);
        #5;
        chk("R10", "no stale edge", raw_status, 8'h00);
        idle(3);

        // mixed pseudo-random phase
        tag = "R3/R4/R5";
        lfsr = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            line_i = lfsr[N-1:0] ^ lfsr[15:8];
            if (lfsr[3:1] == 3'b101) begin
                wr_en = 1'b1;
                case (lfsr[6:4])
                    3'd0: wr_addr = A_MODE;
                    3'd1: wr_addr = A_DUAL;
                    3'd2: wr_addr = A_POL;
                    3'd3: wr_addr = A_EN;
                    3'd4: wr_addr = A_RAW;
                    default: wr_addr = A_CLR;
                endcase
                wr_data = lfsr[15:8];
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule